// File: doc/BRIEF.md
# Five-Channel Compare Timer

This block is a memory-mapped general purpose timer. A 32-bit time base advances by one on every clock and can be reloaded by a register write. Five compare channels watch it. Each channel holds a compare value and a compare mask; mask bits set to one exclude the matching time base bits from the comparison.

Each channel drives one output pin and one interrupt line. When a channel's output is enabled, its pin carries the programmed level while the channel matches and the opposite level otherwise. When a match begins on a channel whose event enable is set, the channel's status bit is set. The interrupt line is the status bit gated by a per-channel mask. Software sets status bits through one address and clears them through another, and both addresses read back the status.

The register port takes whole 32-bit words only. A write takes effect at the clock edge where select and write enable are high. Read data is a combinational function of the address.

Top module: `ctm_timer`

## Requirements
- R1: After reset, output enable, output level, interrupt mask, status, event enable and every compare and compare-mask register read zero, the time base restarts from zero, and all pins and interrupt lines are low.
- R2: The time base (offset 0x00) increases by one every clock and wraps from 0xFFFFFFFF to 0. A write to 0x00 loads the written value at that edge, and counting resumes from it.
- R3: Output enable (0x10) and output level (0x14) hold channel n at bit 31-n. Only bits 31 to 27 are kept on a write, and every other bit reads zero.
- R4: Interrupt mask (0x18) and event enable (0x24) hold channel n at bit 15-n. Only bits 15 to 11 are kept on a write, and every other bit reads zero.
- R5: Status uses the same bit positions as R4. A write to 0x1C ORs the written bits into status, and a write to 0x20 clears the written bits. A read at either address returns the status.
- R6: irq_out[n] is high exactly when status bit n and interrupt mask bit n are both set.
- R7: Channel n matches while (timebase & ~mask[n]) == (compare[n] & ~mask[n]).
- R8: On the first cycle of a match, a channel whose event enable bit is set gets its status bit set at the next edge. The status bit is not set again while the match continues, and it is never set by a match when the event enable bit is clear.
- R9: For a channel with output enable set, pin_out[n] equals its output level bit while it matches and the inverse bit otherwise. A channel with output enable clear drives its pin low.
- R10: Compare registers sit at 0x80+4n and compare-mask registers at 0xC0+4n for n from 0 to 4. All 32 bits are stored and read back.
- R11: Reads at any other offset, including offsets not a multiple of 4, return 0xFFFFFFFF. Writes there change no state.
- R12: A match event that sets a status bit takes priority over a write to 0x20 in the same cycle that clears that bit, so the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register port select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_out | output | 5 | Channel output pins, bit n for channel n |
| irq_out | output | 5 | Channel interrupt lines, bit n for channel n |

## Verification
Register writes and time base loads are visible on the read port at the first sample after the write edge. Pins follow the time base combinationally, so a pin changes in the same cycle the time base reaches or leaves a match value. A match event reaches status and the interrupt line one edge later. The bench loads the time base a fixed number of counts before each compare value, steps one falling edge per count, and samples 1 ns after that edge. This lets each check name the exact time base value at which a pin must flip or a status bit must appear. The case where an event and a clear write meet in the same cycle is driven by placing the clear write in the cycle where the time base equals the compare value.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    // Register word offsets (byte addresses)
    localparam logic [7:0] OFS_TBASE    = 8'h00;
    localparam logic [7:0] OFS_OEN      = 8'h10;
    localparam logic [7:0] OFS_OLVL     = 8'h14;
    localparam logic [7:0] OFS_IMSK     = 8'h18;
    localparam logic [7:0] OFS_ISET     = 8'h1C;
    localparam logic [7:0] OFS_ICLR     = 8'h20;
    localparam logic [7:0] OFS_IEN      = 8'h24;
    localparam logic [7:0] OFS_CMP_BASE = 8'h80;
    localparam logic [7:0] OFS_MSK_BASE = 8'hC0;

    // Top bit of the pin-side and interrupt-side per-channel fields
    localparam int PIN_FIELD_TOP = 31;
    localparam int IRQ_FIELD_TOP = 15;

endpackage

// File: rtl/ctm_timebase.sv
module ctm_timebase #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // R2: free counting advances by exactly one
    assert_tb_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> count == $past(count) + W'(1));

    // R2: a load lands on the next edge
    assert_tb_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));

endmodule

// File: rtl/ctm_channel.sv
module ctm_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tbase,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] cmp_msk,
    input  logic         oen,
    input  logic         olvl,
    output logic         hit_rise,
    output logic         pin
);

    typedef struct packed {
        logic hit;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit      = ((tbase ^ cmp_val) & ~cmp_msk) == '0;
        hit_rise = hit & ~st_q.hit;
        pin      = oen & (hit ? olvl : ~olvl);
        st_d     = st_q;
        st_d.hit = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: an event lasts a single cycle even when the match persists
    assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rise |=> !hit_rise);

    // R9: a disabled channel keeps its pin low
    assert_pin_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !oen |-> !pin);

endmodule

// File: rtl/ctm_regfile.sv
module ctm_regfile
    import ctm_pkg::*;
#(
    parameter int NCH = 5,
    parameter int W   = 32,
    parameter int AW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [W-1:0]          bus_wdata,
    output logic [W-1:0]          bus_rdata,
    input  logic [W-1:0]          tbase,
    input  logic [NCH-1:0]        ch_rise,
    output logic                  tb_load,
    output logic [W-1:0]          tb_val,
    output logic [NCH-1:0]        oen,
    output logic [NCH-1:0]        olvl,
    output logic [NCH-1:0][W-1:0] cmp_val,
    output logic [NCH-1:0][W-1:0] cmp_msk,
    output logic [NCH-1:0]        irq
);

    localparam logic [AW-1:0] A_TBASE = AW'(OFS_TBASE);
    localparam logic [AW-1:0] A_OEN   = AW'(OFS_OEN);
    localparam logic [AW-1:0] A_OLVL  = AW'(OFS_OLVL);
    localparam logic [AW-1:0] A_IMSK  = AW'(OFS_IMSK);
    localparam logic [AW-1:0] A_ISET  = AW'(OFS_ISET);
    localparam logic [AW-1:0] A_ICLR  = AW'(OFS_ICLR);
    localparam logic [AW-1:0] A_IEN   = AW'(OFS_IEN);

    typedef struct packed {
        logic [NCH-1:0]        oen;
        logic [NCH-1:0]        olvl;
        logic [NCH-1:0]        imsk;
        logic [NCH-1:0]        ists;
        logic [NCH-1:0]        ien;
        logic [NCH-1:0][W-1:0] cmp;
        logic [NCH-1:0][W-1:0] msk;
    } rf_state_t;

    rf_state_t      rf_d, rf_q;
    logic           wr;
    logic [NCH-1:0] pin_w, irq_w;
    logic [NCH-1:0] set_v, clr_v, evt_v;

    // Next-state computation
    always_comb begin
        rf_d  = rf_q;
        set_v = '0;
        clr_v = '0;
        wr    = bus_sel & bus_we;
        for (int n = 0; n < NCH; n++) begin
            pin_w[n] = bus_wdata[PIN_FIELD_TOP-n];
            irq_w[n] = bus_wdata[IRQ_FIELD_TOP-n];
        end
        if (wr) begin
            case (bus_addr)
                A_OEN:   rf_d.oen  = pin_w;
                A_OLVL:  rf_d.olvl = pin_w;
                A_IMSK:  rf_d.imsk = irq_w;
                A_ISET:  set_v     = irq_w;
                A_ICLR:  clr_v     = irq_w;
                A_IEN:   rf_d.ien  = irq_w;
                default: begin
                    for (int n = 0; n < NCH; n++) begin
                        if (bus_addr == AW'(OFS_CMP_BASE + 4 * n)) begin
                            rf_d.cmp[n] = bus_wdata;
                        end
                        if (bus_addr == AW'(OFS_MSK_BASE + 4 * n)) begin
                            rf_d.msk[n] = bus_wdata;
                        end
                    end
                end
            endcase
        end
        // Hardware events are applied after software clears, so they win
        evt_v     = ch_rise & rf_q.ien;
        rf_d.ists = ((rf_q.ists | set_v) & ~clr_v) | evt_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    // Read path
    always_comb begin
        logic [W-1:0] oen_rd, olvl_rd, imsk_rd, ists_rd, ien_rd;
        oen_rd  = '0;
        olvl_rd = '0;
        imsk_rd = '0;
        ists_rd = '0;
        ien_rd  = '0;
        for (int n = 0; n < NCH; n++) begin
            oen_rd[PIN_FIELD_TOP-n]  = rf_q.oen[n];
            olvl_rd[PIN_FIELD_TOP-n] = rf_q.olvl[n];
            imsk_rd[IRQ_FIELD_TOP-n] = rf_q.imsk[n];
            ists_rd[IRQ_FIELD_TOP-n] = rf_q.ists[n];
            ien_rd[IRQ_FIELD_TOP-n]  = rf_q.ien[n];
        end
        bus_rdata = '1;
        case (bus_addr)
            A_TBASE: bus_rdata = tbase;
            A_OEN:   bus_rdata = oen_rd;
            A_OLVL:  bus_rdata = olvl_rd;
            A_IMSK:  bus_rdata = imsk_rd;
            A_ISET:  bus_rdata = ists_rd;
            A_ICLR:  bus_rdata = ists_rd;
            A_IEN:   bus_rdata = ien_rd;
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (bus_addr == AW'(OFS_CMP_BASE + 4 * n)) begin
                        bus_rdata = rf_q.cmp[n];
                    end
                    if (bus_addr == AW'(OFS_MSK_BASE + 4 * n)) begin
                        bus_rdata = rf_q.msk[n];
                    end
                end
            end
        endcase
    end

    assign tb_load = wr && (bus_addr == A_TBASE);
    assign tb_val  = bus_wdata;
    assign oen     = rf_q.oen;
    assign olvl    = rf_q.olvl;
    assign cmp_val = rf_q.cmp;
    assign cmp_msk = rf_q.msk;
    assign irq     = rf_q.ists & rf_q.imsk;

    // R5: bits written to the set address are present afterwards
    assert_iset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((rf_q.ists & $past(set_v)) == $past(set_v)));

    // R5: bits written to the clear address are gone when no event competes
    assert_iclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|clr_v) && !(|evt_v)) |=> ((rf_q.ists & $past(clr_v)) == '0));

    // R5: without writes or events the status does not move
    assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|set_v) && !(|clr_v) && !(|evt_v)) |=> $stable(rf_q.ists));

    // R8, R12: an enabled match event always leaves its status bit set
    assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_v) |=> ((rf_q.ists & $past(evt_v)) == $past(evt_v)));

endmodule

// File: rtl/ctm_timer.sv
module ctm_timer #(
    parameter int NCH = 5,
    parameter int W   = 32,
    parameter int AW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [W-1:0]   bus_wdata,
    output logic [W-1:0]   bus_rdata,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] irq_out
);

    logic                  tb_load;
    logic [W-1:0]          tb_val;
    logic [W-1:0]          tbase;
    logic [NCH-1:0]        oen, olvl, ch_rise;
    logic [NCH-1:0][W-1:0] cmp_val, cmp_msk;

    ctm_timebase #(.W(W)) u_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tb_load),
        .load_val (tb_val),
        .count    (tbase)
    );

    ctm_regfile #(.NCH(NCH), .W(W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tbase     (tbase),
        .ch_rise   (ch_rise),
        .tb_load   (tb_load),
        .tb_val    (tb_val),
        .oen       (oen),
        .olvl      (olvl),
        .cmp_val   (cmp_val),
        .cmp_msk   (cmp_msk),
        .irq       (irq_out)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ctm_channel #(.W(W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tbase    (tbase),
            .cmp_val  (cmp_val[g]),
            .cmp_msk  (cmp_msk[g]),
            .oen      (oen[g]),
            .olvl     (olvl[g]),
            .hit_rise (ch_rise[g]),
            .pin      (pin_out[g])
        );
    end

endmodule

// File: tb/tb_ctm_timer.sv
module tb_ctm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  pin_out, irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ctm_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic step_chk(input string req, input logic [4:0] pin_exp, input logic [4:0] irq_exp);
        @(negedge clk);
        #1;
        chk({req, " pin"}, {27'd0, pin_out}, {27'd0, pin_exp});
        chk({req, " irq"}, {27'd0, irq_out}, {27'd0, irq_exp});
    endtask

    task automatic test_reset;
        #1;
        chk("R1 pins", {27'd0, pin_out}, 32'd0);
        chk("R1 irqs", {27'd0, irq_out}, 32'd0);
        rd_chk("R1 tbase after one edge", 8'h00, 32'd1);
        rd_chk("R1 oen", 8'h10, 32'd0);
        rd_chk("R1 olvl", 8'h14, 32'd0);
        rd_chk("R1 imsk", 8'h18, 32'd0);
        rd_chk("R1 status", 8'h1C, 32'd0);
        rd_chk("R1 ien", 8'h24, 32'd0);
        for (int n = 0; n < 5; n++) begin
            rd_chk("R1 cmp", 8'(8'h80 + 4 * n), 32'd0);
            rd_chk("R1 msk", 8'(8'hC0 + 4 * n), 32'd0);
        end
    endtask

    task automatic test_timebase;
        wr(8'h00, 32'h0000_1000);
        rd_chk("R2 count after load", 8'h00, 32'h0000_1001);
        repeat (4) @(negedge clk);
        rd_chk("R2 steady count", 8'h00, 32'h0000_1006);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 wrap", 8'h00, 32'h0000_0000);
    endtask

    task automatic test_fields;
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk("R3 oen field", 8'h10, 32'hF800_0000);
        wr(8'h14, 32'hA7FF_FFFF);
        rd_chk("R3 olvl field", 8'h14, 32'hA000_0000);
        wr(8'h18, 32'hFFFF_FFFF);
        rd_chk("R4 imsk field", 8'h18, 32'h0000_F800);
        wr(8'h24, 32'hFFFF_5000);
        rd_chk("R4 ien field", 8'h24, 32'h0000_5000);
        wr(8'h10, 32'd0);
        wr(8'h14, 32'd0);
        wr(8'h18, 32'd0);
        wr(8'h24, 32'd0);
        #1;
        chk("R9 all disabled pins low", {27'd0, pin_out}, 32'd0);
    endtask

    task automatic test_status;
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk("R5 status via set addr", 8'h1C, 32'h0000_F800);
        rd_chk("R5 status via clr addr", 8'h20, 32'h0000_F800);
        wr(8'h20, 32'h0000_9000);
        rd_chk("R5 partial clear", 8'h1C, 32'h0000_6800);
        #1;
        chk("R6 no mask no irq", {27'd0, irq_out}, 32'd0);
        wr(8'h18, 32'h0000_4000);
        #1;
        chk("R6 ch1 gated irq", {27'd0, irq_out}, 32'h0000_0002);
        wr(8'h1C, 32'h0000_0800);
        wr(8'h18, 32'h0000_C800);
        #1;
        chk("R6 ch1 ch4 irq", {27'd0, irq_out}, 32'h0000_0012);
        wr(8'h20, 32'hFFFF_FFFF);
        #1;
        chk("R6 cleared irq", {27'd0, irq_out}, 32'd0);
        wr(8'h18, 32'd0);
    endtask

    task automatic test_cmp_regs;
        for (int n = 0; n < 5; n++) begin
            wr(8'(8'h80 + 4 * n), 32'h1111_1111 * (n + 1));
            wr(8'(8'hC0 + 4 * n), ~(32'h1111_1111 * (n + 1)));
        end
        for (int n = 0; n < 5; n++) begin
            rd_chk("R10 cmp readback", 8'(8'h80 + 4 * n), 32'h1111_1111 * (n + 1));
            rd_chk("R10 msk readback", 8'(8'hC0 + 4 * n), ~(32'h1111_1111 * (n + 1)));
        end
        rd_chk("R11 unmapped 0x04", 8'h04, 32'hFFFF_FFFF);
        rd_chk("R11 unmapped 0x28", 8'h28, 32'hFFFF_FFFF);
        rd_chk("R11 unmapped 0x94", 8'h94, 32'hFFFF_FFFF);
        rd_chk("R11 unmapped 0xD4", 8'hD4, 32'hFFFF_FFFF);
        rd_chk("R11 unaligned 0x81", 8'h81, 32'hFFFF_FFFF);
        wr(8'h94, 32'hDEAD_BEEF);
        wr(8'h81, 32'hDEAD_BEEF);
        wr(8'hD4, 32'hDEAD_BEEF);
        rd_chk("R11 cmp0 untouched", 8'h80, 32'h1111_1111);
        rd_chk("R11 cmp4 untouched", 8'h90, 32'h5555_5555);
        rd_chk("R11 msk4 untouched", 8'hD0, 32'hAAAA_AAAA);
        rd_chk("R11 status untouched", 8'h1C, 32'd0);
        for (int n = 0; n < 5; n++) begin
            wr(8'(8'h80 + 4 * n), 32'd0);
            wr(8'(8'hC0 + 4 * n), 32'd0);
        end
    endtask

    task automatic test_match;
        wr(8'h00, 32'h0010_0000);
        wr(8'h88, 32'h0000_0500);
        wr(8'hC8, 32'd0);
        wr(8'h10, 32'h2000_0000);
        wr(8'h14, 32'd0);
        wr(8'h24, 32'h0000_2000);
        wr(8'h18, 32'h0000_2000);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0000_04FD);
        #1;
        chk("R9 no match inverse level", {27'd0, pin_out}, 32'h0000_0004);
        step_chk("R9 tb 0x4FE", 5'b00100, 5'b00000);
        step_chk("R9 tb 0x4FF", 5'b00100, 5'b00000);
        step_chk("R7 R9 match at 0x500", 5'b00000, 5'b00000);
        step_chk("R8 status one edge later", 5'b00100, 5'b00100);
        rd_chk("R8 status bit ch2", 8'h1C, 32'h0000_2000);
        // masked compare
        wr(8'hC8, 32'h0000_000F);
        wr(8'h88, 32'h0000_0700);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0000_06FE);
        #1;
        chk("R7 masked no match 0x6FE", {27'd0, pin_out}, 32'h0000_0004);
        step_chk("R7 tb 0x6FF", 5'b00100, 5'b00000);
        step_chk("R7 masked match 0x700", 5'b00000, 5'b00000);
        step_chk("R8 masked event", 5'b00000, 5'b00100);
        wr(8'h20, 32'h0000_2000);
        #1;
        chk("R5 clear during match", {27'd0, irq_out}, 32'd0);
        repeat (3) @(negedge clk);
        #1;
        chk("R8 no retrigger irq", {27'd0, irq_out}, 32'd0);
        chk("R7 still matching", {27'd0, pin_out}, 32'd0);
        repeat (9) @(negedge clk);
        #1;
        chk("R7 last masked match 0x70F", {27'd0, pin_out}, 32'd0);
        step_chk("R7 leaves match 0x710", 5'b00100, 5'b00000);
        rd_chk("R8 no retrigger status", 8'h1C, 32'd0);
        // event enable off
        wr(8'h24, 32'd0);
        wr(8'h00, 32'h0000_06FE);
        repeat (3) @(negedge clk);
        #1;
        chk("R8 disabled event no irq", {27'd0, irq_out}, 32'd0);
        rd_chk("R8 disabled event no status", 8'h1C, 32'd0);
        wr(8'h14, 32'h2000_0000);
        #1;
        chk("R9 level high while matching", {27'd0, pin_out}, 32'h0000_0004);
        wr(8'h10, 32'd0);
        #1;
        chk("R9 disabled pin low", {27'd0, pin_out}, 32'd0);
    endtask

    task automatic test_set_wins;
        wr(8'h88, 32'h0000_0500);
        wr(8'hC8, 32'd0);
        wr(8'h24, 32'h0000_2000);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0000_04FD);
        @(negedge clk);
        @(negedge clk);
        wr(8'h20, 32'h0000_2000);
        #1;
        chk("R12 event beats clear irq", {27'd0, irq_out}, 32'h0000_0004);
        rd_chk("R12 event beats clear status", 8'h1C, 32'h0000_2000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset;
        test_timebase;
        test_fields;
        test_status;
        test_cmp_regs;
        test_match;
        test_set_wins;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule